// File: doc/BRIEF.md
# Fractional-Delay Trapezoid Edge Generator

This block turns a programmed period into a stream of DAC sample words that describe a square wave with slope-limited edges. The output sits at full-scale low or full-scale high between edges. Around each edge it plays a short straight ramp. Every ramp has the same slope. The only difference between ramps is a sub-tick offset, so once the staircase is filtered, the zero crossing falls between two clock ticks. That offset comes from the fractional part of a running edge time. The running edge time is advanced by the programmed delay once per edge.

The delay word has an integer tick count in its upper bits and a binary fraction of a tick in its lower bits. A load strobe writes the word into a pending register. The first load also starts the wave. After that, the pending word is consumed only when a ramp starts, so a new period never produces a runt interval. Ramp samples are computed with arithmetic, so no table is stored. The DAC code and the edge marker both come out of registers.

Top module: `trap_edge_gen`

## Requirements
- R1: While reset is asserted, and from reset until the first load strobe, `dac_o` is 0 and `edge_o` is 0.
- R2: Outside a ramp, `dac_o` holds 2^DAC_W−1 when the level is high and 0 when it is low. The first ramp rises, and each later ramp reverses the level.
- R3: A ramp is RAMP_LEN samples long. Sample k (k = 0..RAMP_LEN−1) has the value MID ± (S·(k − RAMP_LEN/2) − ⌊S·f / 2^FRAC_W⌋), clamped to [0, 2^DAC_W−1]. Here MID = 2^(DAC_W−1), S = 2^DAC_W / RAMP_LEN, f is the ramp's fraction, and the sign is + for a rising ramp and − for a falling one.
- R4: Each ramp start adds the pending delay fraction to the fraction accumulator. The next ramp starts I + c ticks later, where I is the effective integer part and c is the carry out of that addition. The ramp that starts uses the accumulator value from before the addition.
- R5: `edge_o` is a one-cycle pulse. It is issued together with sample k = RAMP_LEN/2, the interval that contains the crossing.
- R6: An integer delay part below RAMP_LEN is treated as RAMP_LEN, so consecutive ramps never overlap.
- R7: A delay loaded while the wave runs does not change the interval already in progress. It sets the interval that begins at the next ramp start.
- R8: When the block is idle, a load strobe sampled at clock edge L starts the first ramp. Its sample k = 0 appears on `dac_o` after edge L+2, and its sample k = 1 after edge L+3.
- R9: The first ramp after the start uses fraction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Writes `dly_i` into the pending delay register; the first load starts the wave |
| dly_i | input | INT_W+FRAC_W | Period delay: integer ticks in the upper INT_W bits, fraction of a tick in the lower FRAC_W bits |
| dac_o | output | DAC_W | Registered DAC sample word |
| edge_o | output | 1 | Registered marker, high with the crossing sample of each ramp |

## Verification
The bench drives delays whose fractions never carry, delays that carry on every other edge (such as 16.5), and an odd fraction that wanders through many ramp offsets. A design with a wrong carry would drift by whole ticks, and a wrong ramp offset would misplace the crossing inside the ramp. A delay below the ramp length checks the clamp; a design without the clamp would overlap ramps and corrupt their samples. A reload in the middle of an interval checks that the running interval keeps its length; a design that consumed the word at once would shorten the interval in progress. The idle start and the first samples after it expose a wrong pipeline latency or a stale fraction carried over from an earlier run.

// File: rtl/trap_pkg.sv
// Shared types for the trapezoid edge generator.
// Assumes nothing beyond IEEE 1800-2017.
package trap_pkg;

    // Output level between ramps, and the target of the current ramp.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

endpackage

// File: rtl/trap_delay_sched.sv
// Edge-time scheduler. Keeps a pending delay word and a fraction accumulator,
// and counts the ticks until the next ramp start. The first load starts the
// wave; after that the pending word is consumed only at a ramp start.
// Assumes RAMP_LEN fits in INT_W bits.
module trap_delay_sched #(
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 10,
    parameter int RAMP_LEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [INT_W+FRAC_W-1:0] dly_i,
    output logic                    run_o,
    output logic                    start_o,
    output logic [FRAC_W-1:0]       frac_o
);

    localparam int                DLY_W   = INT_W + FRAC_W;
    localparam int                CNT_W   = INT_W + 1;
    localparam logic [INT_W-1:0]  MIN_INT = INT_W'(RAMP_LEN);

    logic [DLY_W-1:0]  pend_q;
    logic              run_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] facc_q;

    logic [INT_W-1:0]  pend_int;
    logic [FRAC_W-1:0] pend_frac;
    logic [INT_W-1:0]  eff_int;
    logic              carry;
    logic [FRAC_W-1:0] fsum;
    logic [CNT_W-1:0]  reload;
    logic              start;

    // Split the pending word, clamp the integer part, and form the next interval.
    always_comb begin
        pend_int      = pend_q[DLY_W-1:FRAC_W];
        pend_frac     = pend_q[FRAC_W-1:0];
        eff_int       = (pend_int < MIN_INT) ? MIN_INT : pend_int;
        {carry, fsum} = {1'b0, facc_q} + {1'b0, pend_frac};
        reload        = {1'b0, eff_int} + {{INT_W{1'b0}}, carry} - CNT_W'(1);
        start         = run_q && (cnt_q == '0);
    end

    // Pending delay register: every load strobe overwrites it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load_i) begin
            pend_q <= dly_i;
        end
    end

    // Run flag, tick countdown and fraction accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            facc_q <= '0;
        end else if (!run_q) begin
            if (load_i) begin
                run_q  <= 1'b1;
                cnt_q  <= '0;
                facc_q <= '0;
            end
        end else if (start) begin
            cnt_q  <= reload;
            facc_q <= fsum;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign run_o   = run_q;
    assign start_o = start;
    assign frac_o  = facc_q;

endmodule

// File: rtl/trap_ramp_seq.sv
// Ramp sequencer. On a start it captures the ramp fraction, flips the level
// and steps the sample index through 0..RAMP_LEN-1.
// Assumes starts are at least RAMP_LEN ticks apart.
module trap_ramp_seq
    import trap_pkg::*;
#(
    parameter int FRAC_W   = 10,
    parameter int RAMP_LEN = 16,
    parameter int K_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              act_o,
    output logic [K_W-1:0]    k_o,
    output logic [FRAC_W-1:0] frac_o,
    output level_e            lvl_o
);

    localparam logic [K_W-1:0] K_LAST = K_W'(RAMP_LEN - 1);

    logic              act_q;
    logic [K_W-1:0]    k_q;
    logic [FRAC_W-1:0] frac_q;
    level_e            lvl_q;

    // Start a ramp or advance the running one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            k_q    <= '0;
            frac_q <= '0;
            lvl_q  <= LVL_LOW;
        end else if (start_i) begin
            act_q  <= 1'b1;
            k_q    <= '0;
            frac_q <= frac_i;
            lvl_q  <= (lvl_q == LVL_LOW) ? LVL_HIGH : LVL_LOW;
        end else if (act_q) begin
            if (k_q == K_LAST) begin
                act_q <= 1'b0;
            end else begin
                k_q <= k_q + K_W'(1);
            end
        end
    end

    assign act_o  = act_q;
    assign k_o    = k_q;
    assign frac_o = frac_q;
    assign lvl_o  = lvl_q;

endmodule

// File: rtl/trap_sample_gen.sv
// Sample generator. Computes the ramp sample MID +/- (S*(k-HALF) - S*f/2^FRAC_W),
// clamps it to the DAC range, or holds full scale outside a ramp. Both the
// DAC word and the edge marker leave through registers.
// Assumes RAMP_LEN is a power of two no larger than 2^DAC_W.
module trap_sample_gen
    import trap_pkg::*;
#(
    parameter int DAC_W    = 14,
    parameter int FRAC_W   = 10,
    parameter int RAMP_LEN = 16,
    parameter int K_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [K_W-1:0]    k_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  level_e            lvl_i,
    output logic [DAC_W-1:0]  dac_o,
    output logic              edge_o
);

    localparam int                    SW      = DAC_W + 4;
    localparam int                    OFF_W   = DAC_W + FRAC_W;
    localparam int                    SLOPE   = (2 ** DAC_W) / RAMP_LEN;
    localparam logic [DAC_W-1:0]      SLOPE_U = DAC_W'(SLOPE);
    localparam logic signed [SW-1:0]  SLOPE_S = SW'(SLOPE);
    localparam logic signed [SW-1:0]  HALF_S  = SW'(RAMP_LEN / 2);
    localparam logic signed [SW-1:0]  MID_S   = SW'(2 ** (DAC_W - 1));
    localparam logic signed [SW-1:0]  MAX_S   = SW'(2 ** DAC_W - 1);
    localparam logic [DAC_W-1:0]      DAC_MAX = '1;
    localparam logic [K_W-1:0]        K_MID   = K_W'(RAMP_LEN / 2);

    logic [OFF_W-1:0]      off_p;
    logic signed [SW-1:0]  off_s;
    logic signed [SW-1:0]  kd;
    logic signed [SW-1:0]  mag;
    logic signed [SW-1:0]  val;
    logic [DAC_W-1:0]      smp;

    // Ramp arithmetic and clamping.
    always_comb begin
        off_p = {{FRAC_W{1'b0}}, SLOPE_U} * {{DAC_W{1'b0}}, frac_i};
        off_s = $signed({{(SW-DAC_W){1'b0}}, off_p[OFF_W-1:FRAC_W]});
        kd    = $signed({{(SW-K_W){1'b0}}, k_i}) - HALF_S;
        mag   = (SLOPE_S * kd) - off_s;
        val   = (lvl_i == LVL_HIGH) ? (MID_S + mag) : (MID_S - mag);
        if (!act_i) begin
            smp = (lvl_i == LVL_HIGH) ? DAC_MAX : '0;
        end else if (val < 0) begin
            smp = '0;
        end else if (val > MAX_S) begin
            smp = DAC_MAX;
        end else begin
            smp = val[DAC_W-1:0];
        end
    end

    // Output registers for the DAC word and the crossing marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_o  <= '0;
            edge_o <= 1'b0;
        end else begin
            dac_o  <= smp;
            edge_o <= act_i && (k_i == K_MID);
        end
    end

endmodule

// File: rtl/trap_edge_gen.sv
// Top of the fractional-delay trapezoid edge generator: scheduler, ramp
// sequencer and sample generator in a chain.
// Assumes DAC_W >= 2 and RAMP_LEN a power of two, at least 2.
module trap_edge_gen
    import trap_pkg::*;
#(
    parameter int DAC_W    = 14,
    parameter int FRAC_W   = 10,
    parameter int INT_W    = 16,
    parameter int RAMP_LEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [INT_W+FRAC_W-1:0] dly_i,
    output logic [DAC_W-1:0]        dac_o,
    output logic                    edge_o
);

    localparam int K_W = $clog2(RAMP_LEN);

    logic              run_w;
    logic              start_w;
    logic [FRAC_W-1:0] sfrac_w;
    logic              act_w;
    logic [K_W-1:0]    k_w;
    logic [FRAC_W-1:0] rfrac_w;
    level_e            lvl_w;

    trap_delay_sched #(
        .INT_W    (INT_W),
        .FRAC_W   (FRAC_W),
        .RAMP_LEN (RAMP_LEN)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .dly_i   (dly_i),
        .run_o   (run_w),
        .start_o (start_w),
        .frac_o  (sfrac_w)
    );

    trap_ramp_seq #(
        .FRAC_W   (FRAC_W),
        .RAMP_LEN (RAMP_LEN),
        .K_W      (K_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .frac_i  (sfrac_w),
        .act_o   (act_w),
        .k_o     (k_w),
        .frac_o  (rfrac_w),
        .lvl_o   (lvl_w)
    );

    trap_sample_gen #(
        .DAC_W    (DAC_W),
        .FRAC_W   (FRAC_W),
        .RAMP_LEN (RAMP_LEN),
        .K_W      (K_W)
    ) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act_w),
        .k_i    (k_w),
        .frac_i (rfrac_w),
        .lvl_i  (lvl_w),
        .dac_o  (dac_o),
        .edge_o (edge_o)
    );

endmodule

// File: rtl/trap_edge_gen_chk.sv
// Property checker for trap_edge_gen, attached with bind below.
// Watches the scheduler and sequencer state and the registered outputs.
module trap_edge_gen_chk #(
    parameter int DAC_W    = 14,
    parameter int RAMP_LEN = 16,
    parameter int K_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             start,
    input logic             act,
    input logic [K_W-1:0]   k,
    input logic             lvl,
    input logic [DAC_W-1:0] dac,
    input logic             edge_mk
);

    localparam logic [DAC_W-1:0] DAC_MAX = '1;

    logic [7:0] gap_q;
    logic       seen_q;

    // Saturating count of cycles since the last ramp start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (dac == '0 && !edge_mk));

    // R2
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && lvl) |=> (dac == DAC_MAX));

    // R2
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !act && !lvl) |=> (dac == '0));

    // R3
    ramp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && k == '0) |=> (dac == (lvl ? '0 : DAC_MAX)));

    // R5
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mk |=> !edge_mk);

    // R6
    ramp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seen_q) |-> (gap_q >= 8'(RAMP_LEN - 1)));

endmodule

bind trap_edge_gen trap_edge_gen_chk #(
    .DAC_W    (DAC_W),
    .RAMP_LEN (RAMP_LEN),
    .K_W      (K_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .start   (start_w),
    .act     (act_w),
    .k       (k_w),
    .lvl     (lvl_w),
    .dac     (dac_o),
    .edge_mk (edge_o)
);

// File: tb/trap_edge_gen_tb.sv
`timescale 1ns/1ps
module trap_edge_gen_tb;

    localparam int DW = 14;
    localparam int FW = 10;
    localparam int IW = 16;
    localparam int RL = 16;
    localparam int DMAX = (1 << DW) - 1;
    localparam int MID = 1 << (DW - 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_i = 1'b0;
    logic [IW+FW-1:0]   dly_i = '0;
    logic [DW-1:0]      dac_o;
    logic               edge_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    trap_edge_gen #(.DAC_W(DW), .FRAC_W(FW), .INT_W(IW), .RAMP_LEN(RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .dly_i(dly_i),
        .dac_o(dac_o), .edge_o(edge_o)
    );

    always #2.5 clk = ~clk;

    // Ramp sample from the requirement formula (R3).
    function automatic int ramp_val(int k, int f, bit rising);
        int sl = (1 << DW) / RL;
        int off = (sl * f) >> FW;
        int m = sl * (k - RL / 2) - off;
        int v = rising ? MID + m : MID - m;
        if (v < 0) v = 0;
        if (v > DMAX) v = DMAX;
        return v;
    endfunction

    // Behavioural reference: absolute tick times of ramp starts.
    int  tick = 0;
    bit  m_run = 0;
    int  m_next = 0;
    int  m_rstart = -1000;
    int  m_rfrac = 0;
    bit  m_lvl = 0;
    int  m_facc = 0;
    int  m_pint = 0;
    int  m_pfrac = 0;
    int  exp_dac = 0;
    bit  exp_edge = 0;
    string exp_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            tick = 0; m_run = 0; m_next = 0; m_rstart = -1000; m_rfrac = 0;
            m_lvl = 0; m_facc = 0; m_pint = 0; m_pfrac = 0;
            exp_dac = 0; exp_edge = 0; exp_tag = "R1";
        end else begin
            int k;
            tick = tick + 1;
            k = tick - 1 - m_rstart;
            if (!m_run || m_rstart < 0) begin
                exp_dac = 0; exp_edge = 0; exp_tag = "R1";
            end else if (k >= 0 && k < RL) begin
                exp_dac = ramp_val(k, m_rfrac, m_lvl); exp_edge = (k == RL / 2); exp_tag = "R3";
            end else begin
                exp_dac = m_lvl ? DMAX : 0; exp_edge = 0; exp_tag = "R2";
            end
            if (m_run && tick == m_next) begin
                int eff, s;
                m_rstart = tick;
                m_rfrac = m_facc;
                m_lvl = ~m_lvl;
                eff = (m_pint < RL) ? RL : m_pint;
                s = m_facc + m_pfrac;
                m_next = tick + eff + ((s >= (1 << FW)) ? 1 : 0);
                m_facc = s % (1 << FW);
            end
            if (!m_run && load_i) begin
                m_run = 1; m_next = tick + 1; m_facc = 0;
            end
            if (load_i) begin
                m_pint = int'(dly_i[IW+FW-1:FW]);
                m_pfrac = int'(dly_i[FW-1:0]);
            end
        end
    end

    // Compare with the reference every cycle, away from the active edge.
    int edge_ticks[$];
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (int'(dac_o) != exp_dac) begin
                errors++;
                $display("FAIL %s dac_o tick %0d: got %0d expected %0d", exp_tag, tick, dac_o, exp_dac);
            end
            vectors++;
            if (edge_o != exp_edge) begin
                errors++;
                $display("FAIL R5 edge_o tick %0d: got %0d expected %0d", tick, edge_o, exp_edge);
            end
            if (edge_o) edge_ticks.push_back(tick);
        end
    end

    task automatic check(string tag, int got, int expv, string what);
        vectors++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    task automatic load(int ip, int fp);
        @(negedge clk);
        dly_i = {ip[IW-1:0], fp[FW-1:0]};
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1", int'(dac_o), 0, "dac_o in reset");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1", int'(dac_o), 0, "dac_o idle before load");

        // R8, R9: start from idle with 20.0; sample 1 of the rising ramp with fraction 0.
        @(negedge clk);
        dly_i = {16'd20, 10'd0};
        load_i = 1'b1;
        @(negedge clk);            // after edge L
        load_i = 1'b0;
        @(negedge clk);            // after edge L+1
        @(negedge clk);            // after edge L+2: k = 0
        check("R8", int'(dac_o), 0, "first ramp sample k=0");
        @(negedge clk);            // after edge L+3: k = 1
        check("R9", int'(dac_o), ramp_val(1, 0, 1'b1), "first ramp sample k=1 fraction 0");
        repeat (120) @(negedge clk);

        // R4: 16.5 carries on every other edge, spacings 16 and 17.
        load(16, 512);
        repeat (60) @(negedge clk);
        edge_ticks.delete();
        repeat (140) @(negedge clk);
        for (int i = 2; i < edge_ticks.size(); i++) begin
            check("R4", edge_ticks[i] - edge_ticks[i-2], 33, "two-interval span at 16.5");
        end

        // R6: integer part 5 is clamped to the ramp length.
        load(5, 0);
        repeat (60) @(negedge clk);
        edge_ticks.delete();
        repeat (100) @(negedge clk);
        for (int i = 1; i < edge_ticks.size(); i++) begin
            check("R6", edge_ticks[i] - edge_ticks[i-1], 16, "spacing with clamped delay");
        end

        // R7: reload mid-interval; the interval in progress keeps its length.
        load(20, 0);
        repeat (80) @(negedge clk);
        edge_ticks.delete();
        while (edge_ticks.size() == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        load(40, 0);
        repeat (90) @(negedge clk);
        check("R7", edge_ticks[1] - edge_ticks[0], 20, "interval in progress at reload");
        check("R7", edge_ticks[2] - edge_ticks[1], 40, "first interval after reload");

        // R3, R4: an odd fraction walks through many ramp offsets.
        load(17, 307);
        repeat (600) @(negedge clk);
        load(23, 1023);
        repeat (400) @(negedge clk);

        finish_run();
    end

endmodule